// File: doc/BRIEF.md
# Converter Clock Enable and Power-Up Mute Sequencer

This block sits in the digital section of a stereo audio converter. It turns the static strap inputs into control levels and produces the modulator clock enable. A two-level ratio strap sets how the system clock relates to the sample rate, and the block divides that clock down to a 128x sample-rate enable. Two three-level straps are used. Each arrives already resolved by pad logic into a 2-bit level code. One strap selects power-down or the front-end gain. The other selects the serial output format or a test mode.

When the block leaves power-down it holds a mute flag, and the serial output stays LOW while the flag is set. It counts word-select periods, one per rising edge of the externally supplied word-select after synchronisation. It releases the flag only after a programmed number of sample periods, by which time the decimation chain carries trusted data. The converter is a slave, so word-select and the system clock come from outside and are frequency-locked. No data stream passes through this block, so it has no valid/ready interface. All pins are plain levels.

Level codes on both three-level straps: 0 = LOW, 1 = MID, 2 = HIGH, 3 = treated as MID.

Top module: `clkpwr_seq`

## Requirements
- R1: With `ratio_sel` = 0 (system clock at 256x sample rate), `mod_ce` is high for exactly one cycle in every 2 system clock cycles.
- R2: With `ratio_sel` = 1 (system clock at 384x sample rate), `mod_ce` is high for exactly one cycle in every 3 system clock cycles.
- R3: Power strap code 0 (LOW) drives `pwr_down` high. Codes 1, 2 and 3 drive it low.
- R4: `gain_hi` is 1 only for power strap code 2 (HIGH, 6 dB gain). Codes 1 and 3 (MID, 0 dB) and code 0 give 0.
- R5: Format strap code 0 gives `fmt_msbj` = 0 (I2S). Code 2 gives `fmt_msbj` = 1 (MSB-justified). Codes 1 and 3 set `test_mode` = 1 and force `fmt_msbj` = 0. `test_mode` is 0 for codes 0 and 2.
- R6: The decoded controls are registered: they follow a strap change at the first rising clock edge after it. Reset leaves `pwr_down` = 1, `mute` = 1, `gain_hi` = 0, `fmt_msbj` = 0, `test_mode` = 0 and `mod_ce` = 0.
- R7: After `pwr_down` falls, `mute` stays 1 until `MUTE_SAMPLES` rising edges of `ws_in` have been seen. It falls within a few cycles of the last one. Edges that arrive during power-down are not counted.
- R8: `mute` is 1 in every cycle where `pwr_down` is 1. Re-entering power-down clears the sample count, so a later exit needs the full count again.
- R9: Once `mute` has fallen it does not rise again unless `pwr_down` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock, 256x or 384x the sample rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_sel | input | 1 | 0 = 256x system clock, 1 = 384x |
| pwr_lvl | input | 2 | Power/gain strap level code |
| fmt_lvl | input | 2 | Format strap level code |
| ws_in | input | 1 | Word-select from the external master (asynchronous) |
| mod_ce | output | 1 | Modulator clock enable at 128x sample rate |
| pwr_down | output | 1 | Converter power-down |
| gain_hi | output | 1 | 1 = 6 dB front-end gain, 0 = 0 dB |
| fmt_msbj | output | 1 | 1 = MSB-justified output, 0 = I2S |
| test_mode | output | 1 | Format strap is at MID |
| mute | output | 1 | 1 = hold serial output data LOW |

## Verification
The bench counts word-select edges up to one short of the mute length and checks that `mute` is still held. One more edge must release it. A design that is off by one in the count, or that counts both edges of word-select, releases too early or too late. Word-select is also toggled while the block is in power-down, and power-down is re-entered partway through a count. A design that counts during power-down, or keeps the partial count, unmutes early on the next exit. The ratio strap is switched at random points so the divider can be caught while its counter is at 2. A divider that does not wrap there, or that places enables back to back, shows a wrong spacing between `mod_ce` pulses. The MID code and the unused code 3 on both straps check that test mode forces I2S and that 6 dB gain appears only for HIGH.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_RSVD = 2'd3
  } lvl_t;

  localparam int unsigned MOD_RATIO    = 128;
  localparam int unsigned SYS_RATIO_LO = 256;
  localparam int unsigned SYS_RATIO_HI = 384;
  localparam int unsigned DIV_LO       = SYS_RATIO_LO / MOD_RATIO;
  localparam int unsigned DIV_HI       = SYS_RATIO_HI / MOD_RATIO;
  localparam int unsigned DIV_W        = $clog2(DIV_HI);

  typedef struct packed {
    logic pdn;
    logic gain;
    logic msbj;
    logic tmode;
  } mode_t;
endpackage

// File: rtl/clkpwr_div.sv
module clkpwr_div
  import clkpwr_pkg::*;
(
  input  logic clk_sys,
  input  logic rst_n,
  input  logic ratio_sel,
  output logic ce
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last = ratio_sel ? DIV_W'(DIV_HI - 1) : DIV_W'(DIV_LO - 1);

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q >= last)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign ce = (cnt_q == last);
endmodule

// File: rtl/clkpwr_decode.sv
module clkpwr_decode
  import clkpwr_pkg::*;
(
  input  logic       clk_sys,
  input  logic       rst_n,
  input  logic [1:0] pwr_lvl,
  input  logic [1:0] fmt_lvl,
  output mode_t      mode
);
  mode_t nxt;

  always_comb begin
    nxt = '0;
    unique case (lvl_t'(pwr_lvl))
      LVL_LOW:  nxt.pdn  = 1'b1;
      LVL_HIGH: nxt.gain = 1'b1;
      default:  nxt.gain = 1'b0;
    endcase
    unique case (lvl_t'(fmt_lvl))
      LVL_LOW:  nxt.msbj  = 1'b0;
      LVL_HIGH: nxt.msbj  = 1'b1;
      default:  nxt.tmode = 1'b1;
    endcase
  end

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= '0;
      mode.pdn  <= 1'b1;
    end else begin
      mode      <= nxt;
    end
  end
endmodule

// File: rtl/clkpwr_mute.sv
module clkpwr_mute #(
  parameter int unsigned MUTE_SAMPLES = 12288,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_sys,
  input  logic rst_n,
  input  logic pdn,
  input  logic ws_in,
  output logic mute
);
  localparam int unsigned CNT_W = $clog2(MUTE_SAMPLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(MUTE_SAMPLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ws_prev_q;
  logic                   ws_rise;
  logic [CNT_W-1:0]       cnt_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n)  sync_q[g] <= 1'b0;
      else         sync_q[g] <= (g == 0) ? ws_in : sync_q[(g == 0) ? 0 : g - 1];
    end
  end

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n)  ws_prev_q <= 1'b0;
    else         ws_prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign ws_rise = sync_q[SYNC_STAGES-1] & ~ws_prev_q;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (pdn)                        cnt_q <= '0;
    else if (ws_rise && cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
  end

  assign mute = pdn | (cnt_q != CNT_END);
endmodule

// File: rtl/clkpwr_seq.sv
module clkpwr_seq
  import clkpwr_pkg::*;
#(
  parameter int unsigned MUTE_SAMPLES = 12288,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk_sys,
  input  logic       rst_n,
  input  logic       ratio_sel,
  input  logic [1:0] pwr_lvl,
  input  logic [1:0] fmt_lvl,
  input  logic       ws_in,
  output logic       mod_ce,
  output logic       pwr_down,
  output logic       gain_hi,
  output logic       fmt_msbj,
  output logic       test_mode,
  output logic       mute
);
  mode_t mode;

  clkpwr_div u_div (
    .clk_sys   (clk_sys),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .ce        (mod_ce)
  );

  clkpwr_decode u_dec (
    .clk_sys (clk_sys),
    .rst_n   (rst_n),
    .pwr_lvl (pwr_lvl),
    .fmt_lvl (fmt_lvl),
    .mode    (mode)
  );

  clkpwr_mute #(
    .MUTE_SAMPLES (MUTE_SAMPLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_mute (
    .clk_sys (clk_sys),
    .rst_n   (rst_n),
    .pdn     (mode.pdn),
    .ws_in   (ws_in),
    .mute    (mute)
  );

  assign pwr_down  = mode.pdn;
  assign gain_hi   = mode.gain;
  assign fmt_msbj  = mode.msbj;
  assign test_mode = mode.tmode;
endmodule

// File: rtl/clkpwr_seq_chk.sv
module clkpwr_seq_chk (
  input logic clk_sys,
  input logic rst_n,
  input logic ratio_sel,
  input logic mod_ce,
  input logic pwr_down,
  input logic gain_hi,
  input logic fmt_msbj,
  input logic test_mode,
  input logic mute
);
  AST_CE_NOT_BACK_TO_BACK: assert property (@(posedge clk_sys) disable iff (!rst_n)
    mod_ce |=> !mod_ce); // R1

  AST_CE_DIV3_GAP: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (mod_ce && ratio_sel) ##1 ratio_sel |-> !mod_ce); // R2

  AST_PDN_NO_GAIN: assert property (@(posedge clk_sys) disable iff (!rst_n)
    pwr_down |-> !gain_hi); // R4

  AST_TEST_FORCES_I2S: assert property (@(posedge clk_sys) disable iff (!rst_n)
    test_mode |-> !fmt_msbj); // R5

  AST_PDN_MUTES: assert property (@(posedge clk_sys) disable iff (!rst_n)
    pwr_down |-> mute); // R8

  AST_NO_SPURIOUS_REMUTE: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $rose(mute) |-> pwr_down); // R9
endmodule

bind clkpwr_seq clkpwr_seq_chk u_chk (
  .clk_sys   (clk_sys),
  .rst_n     (rst_n),
  .ratio_sel (ratio_sel),
  .mod_ce    (mod_ce),
  .pwr_down  (pwr_down),
  .gain_hi   (gain_hi),
  .fmt_msbj  (fmt_msbj),
  .test_mode (test_mode),
  .mute      (mute)
);

// File: tb/clkpwr_seq_tb_top.sv
module clkpwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_MUTE     = 20;

  logic       clk_sys = 1'b0;
  logic       rst_n = 1'b0;
  logic       ratio_sel = 1'b0;
  logic [1:0] pwr_lvl = 2'd0;
  logic [1:0] fmt_lvl = 2'd0;
  logic       ws_in = 1'b0;
  logic       mod_ce, pwr_down, gain_hi, fmt_msbj, test_mode, mute;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk_sys = ~clk_sys;

  clkpwr_seq #(.MUTE_SAMPLES(N_MUTE), .SYNC_STAGES(2)) dut_i (
    .clk_sys (clk_sys), .rst_n (rst_n), .ratio_sel (ratio_sel),
    .pwr_lvl (pwr_lvl), .fmt_lvl (fmt_lvl), .ws_in (ws_in),
    .mod_ce (mod_ce), .pwr_down (pwr_down), .gain_hi (gain_hi),
    .fmt_msbj (fmt_msbj), .test_mode (test_mode), .mute (mute)
  );

  function automatic logic [3:0] exp_mode(input logic [1:0] p, input logic [1:0] f);
    logic pd, g, m, t;
    pd = (p == 2'd0);
    g  = (p == 2'd2);
    m  = (f == 2'd2);
    t  = (f == 2'd1) || (f == 2'd3);
    return {pd, g, m, t};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ws_pulse();
    ws_in = 1'b1;
    repeat (4) @(negedge clk_sys);
    ws_in = 1'b0;
    repeat (4) @(negedge clk_sys);
  endtask

  task automatic check_ce(input logic sel, input string req);
    int exp_div, gap, cnt;
    exp_div = sel ? 3 : 2;
    repeat (4) @(negedge clk_sys);
    while (!mod_ce) @(negedge clk_sys);
    gap = 0;
    do begin
      @(negedge clk_sys);
      gap++;
    end while (!mod_ce && gap < 8);
    check({req, " ce spacing"}, gap, exp_div);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_sys);
      if (mod_ce) cnt++;
    end
    check({req, " ce count in 12 cycles"}, cnt, 12 / exp_div);
  endtask

  task automatic check_decode(input string req);
    logic [3:0] e;
    e = exp_mode(pwr_lvl, fmt_lvl);
    check({req, " pwr_down"},  pwr_down,  e[3]);
    check({req, " gain_hi"},   gain_hi,   e[2]);
    check({req, " fmt_msbj"},  fmt_msbj,  e[1]);
    check({req, " test_mode"}, test_mode, e[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_sys);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4217));
    repeat (3) @(negedge clk_sys);
    // R6 reset state
    check("R6 reset pwr_down", pwr_down, 1);
    check("R6 reset mute", mute, 1);
    check("R6 reset gain_hi", gain_hi, 0);
    check("R6 reset fmt_msbj", fmt_msbj, 0);
    check("R6 reset test_mode", test_mode, 0);
    check("R6 reset mod_ce", mod_ce, 0);
    rst_n = 1'b1;

    // R1 / R2 directed
    ratio_sel = 1'b0; check_ce(1'b0, "R1");
    ratio_sel = 1'b1; check_ce(1'b1, "R2");

    // R6 one-cycle latency, R3 power-down code
    pwr_lvl = 2'd2; fmt_lvl = 2'd2;
    @(negedge clk_sys);
    check_decode("R6 latency");
    pwr_lvl = 2'd0;
    @(negedge clk_sys);
    check("R3 LOW gives power-down", pwr_down, 1);
    check("R8 mute in power-down", mute, 1);

    // R7: edges during power-down are not counted
    for (int i = 0; i < N_MUTE + 2; i++) ws_pulse();
    pwr_lvl = 2'd1;
    repeat (3) @(negedge clk_sys);
    check("R3 MID leaves power-down", pwr_down, 0);
    check("R7 edges in power-down ignored", mute, 1);
    for (int i = 0; i < N_MUTE - 1; i++) ws_pulse();
    check("R7 still muted one edge short", mute, 1);
    ws_pulse();
    check("R7 released after full count", mute, 0);
    for (int i = 0; i < 3; i++) ws_pulse();
    check("R9 stays released", mute, 0);

    // R8: re-enter power-down mid count, count restarts
    pwr_lvl = 2'd0;
    @(negedge clk_sys);
    check("R8 immediate mute", mute, 1);
    pwr_lvl = 2'd2;
    repeat (3) @(negedge clk_sys);
    for (int i = 0; i < N_MUTE / 2; i++) ws_pulse();
    pwr_lvl = 2'd0;
    @(negedge clk_sys);
    check("R8 mute on re-entry", mute, 1);
    pwr_lvl = 2'd1;
    repeat (3) @(negedge clk_sys);
    for (int i = 0; i < N_MUTE - 1; i++) ws_pulse();
    check("R8 partial count discarded", mute, 1);
    ws_pulse();
    check("R8 full count after re-entry", mute, 0);

    // R4 / R5 all code combinations
    for (int p = 0; p < 4; p++) begin
      for (int f = 0; f < 4; f++) begin
        pwr_lvl = 2'(p); fmt_lvl = 2'(f);
        @(negedge clk_sys);
        check_decode("R4 R5 sweep");
      end
    end

    // Random mix: ratio switches and strap codes
    for (int it = 0; it < 30; it++) begin
      repeat ($urandom_range(0, 5)) @(negedge clk_sys);
      ratio_sel = 1'($urandom_range(0, 1));
      pwr_lvl   = 2'($urandom_range(0, 3));
      fmt_lvl   = 2'($urandom_range(0, 3));
      @(negedge clk_sys);
      check_decode("R3 R4 R5 random");
      if (pwr_down) check("R8 random mute", mute, 1);
      check_ce(ratio_sel, ratio_sel ? "R2 random" : "R1 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule